// File: doc/BRIEF.md
# Status-Register NOR Flash Command Engine

This block drives a NOR flash device that uses the status-register command set. A host hands it one request at a time: a word program, a block erase, or a buffered program of up to `BUF_WORDS` words. The engine issues the command writes in the required order and pulls data words from a separate word stream as it needs them. It then polls the device status byte until the ready bit rises, or until a programmable number of polls has been spent. Finally it sends the read-array command so that the device returns to normal reads.

The engine does not report a plain pass/fail result. It sorts the final status byte into distinct failure classes: block locked, command sequence error, erase failure, program failure, low programming voltage, and a separate class for a poll budget that runs out. Every operation begins by clearing the status register, so flags left over from an earlier operation cannot leak into the result. The flash-side bus is simple and synchronous. A write strobe lasts one cycle. A read strobe returns the status byte on `fl_status` in the following cycle.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset the engine is idle: `req_ready` is 1, and `rsp_done`, `wdat_ready`, `fl_we` and `fl_re` are all 0.
- R2: A word program (`req_op`=0) writes, on three consecutive cycles, 0x50, then 0x40, then the next stream word, all to `req_addr`. It then polls status at `req_addr`.
- R3: A block erase (`req_op`=1) writes 0x50, 0x20 and 0xD0 to the block base, then polls status there. The block base is `req_addr` with its low `BLK_AW` bits cleared.
- R4: A buffered program (`req_op`=2, `req_count`=N, 1..BUF_WORDS) writes 0x50 and 0xE8 to the block base and polls there until status bit 7 is set. It then writes N-1 to the block base, writes N stream words in order to `req_addr`..`req_addr`+N-1, and writes 0xD0 to the block base. The final status poll is at `req_addr`+N-1.
- R5: Each status wait issues reads until bit 7 reads 1, with at most `cfg_max_polls` reads in one wait (a limit of 0 acts as 1). A wait that ends with bit 7 still clear gives error code 6. In the buffer-ready wait, that code ends the operation without writing the count or consuming any stream word.
- R6: After the last status read, 0xFF is written once to the address that was polled. `rsp_done` is high for exactly the one cycle after that write.
- R7: The `rsp_err` code comes from the final status byte by priority: bit 1 set gives 4 (locked); otherwise bits 5 and 4 both set give 1 (sequence); bit 5 alone gives 2 (erase); bit 4 alone gives 3 (program); bit 3 gives 5 (low voltage); otherwise 0.
- R8: A request is taken only while `req_ready` is 1. `req_op`=3 is never taken, and `req_valid` while busy has no effect.
- R9: Stream words are written only while `wdat_valid` is 1. While the engine waits for a word, `wdat_ready` stays 1 and no write strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_max_polls | input | PW | Maximum status reads per wait |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request is taken |
| req_op | input | 2 | 0 word program, 1 block erase, 2 buffered program |
| req_addr | input | AW | Target word address |
| req_count | input | CW | Buffered word count |
| wdat_valid | input | 1 | Stream word present |
| wdat_ready | output | 1 | Engine waiting for a stream word |
| wdat | input | DW | Stream word |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 3 | Error class, valid with `rsp_done` |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash status read strobe |
| fl_addr | output | AW | Flash word address |
| fl_wdata | output | DW | Flash write data; commands sit in the low byte |
| fl_status | input | 8 | Status byte, valid the cycle after `fl_re` |

## Verification
The first command write appears on the cycle after the clock edge that accepts the request. Each later command write follows one cycle after the previous one, unless a stream word is missing. Each status read takes two cycles, the strobe and then the sample. The 0xFF write comes one cycle after the deciding sample, and `rsp_done` comes one cycle after that. The bench flash model stamps every write, read and completion with a cycle number at the clock edge. Checks of ordering and latency compare these stamps. All other checks wait for the completion pulse and then sample at a falling edge, when every expected write has already landed.

// File: rtl/fce_pkg.sv
package fce_pkg;

  typedef enum logic [1:0] {
    OP_WORD  = 2'd0,
    OP_ERASE = 2'd1,
    OP_BUF   = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_SEQ     = 3'd1,
    ERR_ERASE   = 3'd2,
    ERR_PROG    = 3'd3,
    ERR_LOCKED  = 3'd4,
    ERR_VPP     = 3'd5,
    ERR_TIMEOUT = 3'd6
  } err_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CLR, S_SETUP, S_WDATA, S_CONF,
    S_BRD, S_BEV, S_CNT, S_BDATA,
    S_PRD, S_PEV, S_RST, S_FIN
  } st_e;

  localparam logic [7:0] CMD_CLR_STATUS = 8'h50;
  localparam logic [7:0] CMD_PROG_SETUP = 8'h40;
  localparam logic [7:0] CMD_ERASE_SET  = 8'h20;
  localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
  localparam logic [7:0] CMD_BUF_LOAD   = 8'hE8;
  localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;

  localparam int SB_READY = 7;
  localparam int SB_ERASE = 5;
  localparam int SB_PROG  = 4;
  localparam int SB_VPP   = 3;
  localparam int SB_LOCK  = 1;

endpackage

// File: rtl/fce_status_decode.sv
module fce_status_decode
  import fce_pkg::*;
(
  input  logic [7:0] status,
  output logic       ready,
  output err_e       code
);
  logic unused_bits;
  assign unused_bits = ^{status[6], status[2], status[0]};

  always_comb begin
    ready = status[SB_READY];
    if (status[SB_LOCK])                          code = ERR_LOCKED;
    else if (status[SB_ERASE] && status[SB_PROG]) code = ERR_SEQ;
    else if (status[SB_ERASE])                    code = ERR_ERASE;
    else if (status[SB_PROG])                     code = ERR_PROG;
    else if (status[SB_VPP])                      code = ERR_VPP;
    else                                          code = ERR_NONE;
  end
endmodule

// File: rtl/fce_poll_timer.sv
module fce_poll_timer #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [PW-1:0] limit,
  output logic          last
);
  logic [PW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr || (tick && (cnt_q != {PW{1'b1}}));
    cnt_d  = clr ? '0 : cnt_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // the sample being judged is read number cnt_q+1
  assign last = ({1'b0, cnt_q} + (PW+1)'(1)) >= {1'b0, limit};
endmodule

// File: rtl/fce_seq.sv
module fce_seq
  import fce_pkg::*;
#(
  parameter int AW     = 24,
  parameter int DW     = 16,
  parameter int BLK_AW = 16,
  parameter int CW     = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] req_count,
  output logic          req_ready,
  input  logic          wdat_valid,
  input  logic [DW-1:0] wdat,
  output logic          wdat_ready,
  output logic          fl_we,
  output logic          fl_re,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata,
  input  logic          st_ready,
  input  err_e          st_code,
  output logic          tmr_clr,
  output logic          tmr_tick,
  input  logic          tmr_last,
  output logic          rsp_done,
  output logic [2:0]    rsp_err
);
  st_e           state_q, state_d;
  op_e           op_q, op_d;
  logic [AW-1:0] dst_q, dst_d;
  logic [AW-1:0] paddr_q, paddr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] idx_q, idx_d;
  err_e          err_q, err_d;
  logic          ld_req;

  logic [AW-1:0] blk_base;
  logic [AW-1:0] word_addr;
  logic [AW-1:0] cmd_addr;

  assign blk_base  = {dst_q[AW-1:BLK_AW], {BLK_AW{1'b0}}};
  assign word_addr = dst_q + AW'(idx_q);
  assign cmd_addr  = (op_q == OP_WORD) ? dst_q : blk_base;
  assign req_ready = (state_q == S_IDLE);
  assign rsp_err   = err_q;
  assign tmr_clr   = !(state_q inside {S_BRD, S_BEV, S_PRD, S_PEV});
  assign ld_req    = (state_q == S_IDLE) && req_valid && (req_op != OP_RSVD);

  always_comb begin
    state_d    = state_q;
    op_d       = op_q;
    dst_d      = dst_q;
    cnt_d      = cnt_q;
    idx_d      = idx_q;
    paddr_d    = paddr_q;
    err_d      = err_q;
    fl_we      = 1'b0;
    fl_re      = 1'b0;
    fl_addr    = cmd_addr;
    fl_wdata   = '0;
    wdat_ready = 1'b0;
    rsp_done   = 1'b0;
    tmr_tick   = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (ld_req) begin
          state_d = S_CLR;
          op_d    = op_e'(req_op);
          dst_d   = req_addr;
          cnt_d   = req_count - CW'(1);
          idx_d   = '0;
          err_d   = ERR_NONE;
        end
      end
      S_CLR: begin
        fl_we    = 1'b1;
        fl_wdata = DW'(CMD_CLR_STATUS);
        state_d  = S_SETUP;
      end
      S_SETUP: begin
        fl_we = 1'b1;
        unique case (op_q)
          OP_WORD: begin
            fl_wdata = DW'(CMD_PROG_SETUP);
            state_d  = S_WDATA;
          end
          OP_ERASE: begin
            fl_wdata = DW'(CMD_ERASE_SET);
            state_d  = S_CONF;
          end
          default: begin
            fl_wdata = DW'(CMD_BUF_LOAD);
            paddr_d  = blk_base;
            state_d  = S_BRD;
          end
        endcase
      end
      S_WDATA: begin
        wdat_ready = 1'b1;
        fl_addr    = word_addr;
        if (wdat_valid) begin
          fl_we    = 1'b1;
          fl_wdata = wdat;
          paddr_d  = word_addr;
          state_d  = S_PRD;
        end
      end
      S_CONF: begin
        fl_we    = 1'b1;
        fl_wdata = DW'(CMD_CONFIRM);
        paddr_d  = (op_q == OP_BUF) ? word_addr : blk_base;
        state_d  = S_PRD;
      end
      S_BRD: begin
        fl_re   = 1'b1;
        fl_addr = paddr_q;
        state_d = S_BEV;
      end
      S_BEV: begin
        tmr_tick = 1'b1;
        fl_addr  = paddr_q;
        if (st_ready) begin
          state_d = S_CNT;
        end else if (tmr_last) begin
          err_d   = ERR_TIMEOUT;
          state_d = S_RST;
        end else begin
          state_d = S_BRD;
        end
      end
      S_CNT: begin
        fl_we    = 1'b1;
        fl_wdata = DW'(cnt_q);
        state_d  = S_BDATA;
      end
      S_BDATA: begin
        wdat_ready = 1'b1;
        fl_addr    = word_addr;
        if (wdat_valid) begin
          fl_we    = 1'b1;
          fl_wdata = wdat;
          if (idx_q == cnt_q) state_d = S_CONF;
          else                idx_d   = idx_q + CW'(1);
        end
      end
      S_PRD: begin
        fl_re   = 1'b1;
        fl_addr = paddr_q;
        state_d = S_PEV;
      end
      S_PEV: begin
        tmr_tick = 1'b1;
        fl_addr  = paddr_q;
        if (st_ready) begin
          err_d   = st_code;
          state_d = S_RST;
        end else if (tmr_last) begin
          err_d   = ERR_TIMEOUT;
          state_d = S_RST;
        end else begin
          state_d = S_PRD;
        end
      end
      S_RST: begin
        fl_we    = 1'b1;
        fl_addr  = paddr_q;
        fl_wdata = DW'(CMD_READ_ARRAY);
        state_d  = S_FIN;
      end
      S_FIN: begin
        rsp_done = 1'b1;
        fl_addr  = paddr_q;
        state_d  = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      paddr_q <= '0;
      idx_q   <= '0;
      err_q   <= ERR_NONE;
    end else begin
      state_q <= state_d;
      paddr_q <= paddr_d;
      idx_q   <= idx_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_WORD;
      dst_q <= '0;
      cnt_q <= '0;
    end else if (ld_req) begin
      op_q  <= op_d;
      dst_q <= dst_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import fce_pkg::*;
#(
  parameter int AW        = 24,
  parameter int DW        = 16,
  parameter int BLK_AW    = 16,
  parameter int BUF_WORDS = 32,
  parameter int PW        = 16,
  localparam int CW       = $clog2(BUF_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] cfg_max_polls,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] req_count,
  input  logic          wdat_valid,
  output logic          wdat_ready,
  input  logic [DW-1:0] wdat,
  output logic          rsp_done,
  output logic [2:0]    rsp_err,
  output logic          fl_we,
  output logic          fl_re,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata,
  input  logic [7:0]    fl_status
);
  logic [1:0] rsync_q;
  logic       rst_int_n;
  logic       st_ready;
  err_e       st_code;
  logic       tmr_clr, tmr_tick, tmr_last;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  fce_status_decode u_dec (
    .status (fl_status),
    .ready  (st_ready),
    .code   (st_code)
  );

  fce_poll_timer #(.PW(PW)) u_tmr (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (tmr_clr),
    .tick  (tmr_tick),
    .limit (cfg_max_polls),
    .last  (tmr_last)
  );

  fce_seq #(.AW(AW), .DW(DW), .BLK_AW(BLK_AW), .CW(CW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_addr   (req_addr),
    .req_count  (req_count),
    .req_ready  (req_ready),
    .wdat_valid (wdat_valid),
    .wdat       (wdat),
    .wdat_ready (wdat_ready),
    .fl_we      (fl_we),
    .fl_re      (fl_re),
    .fl_addr    (fl_addr),
    .fl_wdata   (fl_wdata),
    .st_ready   (st_ready),
    .st_code    (st_code),
    .tmr_clr    (tmr_clr),
    .tmr_tick   (tmr_tick),
    .tmr_last   (tmr_last),
    .rsp_done   (rsp_done),
    .rsp_err    (rsp_err)
  );
endmodule

// File: rtl/fce_checker.sv
module fce_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] req_op,
  input logic       wdat_valid,
  input logic       wdat_ready,
  input logic       fl_we,
  input logic       fl_re,
  input logic [7:0] cmd_byte,
  input logic       rsp_done,
  input logic [2:0] rsp_err
);
  a_r1_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re));

  a_r8_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op != 2'b11) |=> !req_ready);

  a_r8_rsvd_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'b11) |=> req_ready);

  a_r6_ff_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> ($past(fl_we) && $past(cmd_byte) == 8'hFF));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> (!rsp_done && req_ready));

  a_r9_no_write_unfed: assert property (@(posedge clk) disable iff (!rst_n)
    (wdat_ready && !wdat_valid) |-> !fl_we);

  a_r7_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (rsp_err <= 3'd6));
endmodule

bind flash_cmd_engine fce_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_op     (req_op),
  .wdat_valid (wdat_valid),
  .wdat_ready (wdat_ready),
  .fl_we      (fl_we),
  .fl_re      (fl_re),
  .cmd_byte   (fl_wdata[7:0]),
  .rsp_done   (rsp_done),
  .rsp_err    (rsp_err)
);

// File: tb/sim_flash_cmd_engine.sv
`timescale 1ns/1ps
module sim_flash_cmd_engine;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int BLK = 4;
  localparam int PW = 16;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PW-1:0] cfg_max_polls = 16'd8;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [CW-1:0] req_count = '0;
  logic          wdat_valid;
  logic          wdat_ready;
  logic [DW-1:0] wdat;
  logic          rsp_done;
  logic [2:0]    rsp_err;
  logic          fl_we, fl_re;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_wdata;
  logic [7:0]    fl_status = 8'h00;

  always #2 clk = ~clk;

  flash_cmd_engine #(.AW(AW), .DW(DW), .BLK_AW(BLK), .BUF_WORDS(32), .PW(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_max_polls(cfg_max_polls),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_count(req_count),
    .wdat_valid(wdat_valid), .wdat_ready(wdat_ready), .wdat(wdat),
    .rsp_done(rsp_done), .rsp_err(rsp_err),
    .fl_we(fl_we), .fl_re(fl_re), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_status(fl_status)
  );

  int n_chk = 0;
  int n_bad = 0;

  // flash model and logs
  int          cyc = 0;
  logic [AW-1:0] wl_addr [0:1023];
  logic [DW-1:0] wl_data [0:1023];
  int          wl_cyc [0:1023];
  int          wl_n = 0;
  logic [AW-1:0] rl_addr [0:1023];
  int          rl_n = 0;
  int          rd_seen = 0;
  logic        e8_phase = 1'b0;
  int          brdy_after = 0;
  int          done_after = 0;
  logic [7:0]  st_final = 8'h80;
  int          dn_n = 0;
  logic [2:0]  dn_err = '0;
  int          dn_cyc = 0;
  logic [DW-1:0] wq [0:63];
  int          wq_n = 0;
  int          wq_rd = 0;
  logic        wd_hold = 1'b0;

  assign wdat_valid = !wd_hold && (wq_rd < wq_n);
  assign wdat       = wq[wq_rd % 64];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (fl_we) begin
      wl_addr[wl_n % 1024] <= fl_addr;
      wl_data[wl_n % 1024] <= fl_wdata;
      wl_cyc[wl_n % 1024]  <= cyc;
      wl_n     <= wl_n + 1;
      rd_seen  <= 0;
      e8_phase <= (fl_wdata == 16'h00E8);
    end
    if (fl_re) begin
      rl_addr[rl_n % 1024] <= fl_addr;
      rl_n    <= rl_n + 1;
      rd_seen <= rd_seen + 1;
      if (e8_phase) fl_status <= (rd_seen >= brdy_after) ? 8'h80 : 8'h00;
      else          fl_status <= (rd_seen >= done_after) ? st_final : 8'h00;
    end
    if (wdat_valid && wdat_ready) wq_rd <= wq_rd + 1;
    if (rsp_done) begin
      dn_n   <= dn_n + 1;
      dn_err <= rsp_err;
      dn_cyc <= cyc;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_wr(input string tag, input int k, input logic [AW-1:0] a, input logic [DW-1:0] d);
    check(tag, 32'(wl_addr[k % 1024]), 32'(a));
    check(tag, 32'(wl_data[k % 1024]), 32'(d));
  endtask

  task automatic enq(input logic [DW-1:0] d);
    wq[wq_n % 64] = d;
    wq_n++;
  endtask

  task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [CW-1:0] n);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_count = n;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input int prev, input string tag);
    int k = 0;
    while (dn_n == prev && k < 3000) begin
      @(negedge clk);
      k++;
    end
    check({tag, " completion"}, 32'(dn_n), 32'(prev + 1));
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 req_ready", 32'(req_ready), 1);
    check("R1 rsp_done", 32'(rsp_done), 0);
    check("R1 wdat_ready", 32'(wdat_ready), 0);
    check("R1 strobes", 32'({fl_we, fl_re}), 0);
  endtask

  task automatic t_word;
    int b = wl_n; int r = rl_n; int d = dn_n;
    cfg_max_polls = 8; done_after = 2; st_final = 8'h80;
    enq(16'hBEEF);
    issue(2'd0, 24'h000123, 6'd1);
    wait_done(d, "R2");
    check("R2 write count", 32'(wl_n - b), 4);
    chk_wr("R2 clear", b, 24'h000123, 16'h0050);
    chk_wr("R2 setup", b + 1, 24'h000123, 16'h0040);
    chk_wr("R2 data", b + 2, 24'h000123, 16'hBEEF);
    check("R2 consecutive", 32'(wl_cyc[(b+2)%1024] - wl_cyc[b%1024]), 2);
    check("R5 read count", 32'(rl_n - r), 3);
    check("R2 poll addr", 32'(rl_addr[(rl_n-1)%1024]), 32'h000123);
    chk_wr("R6 read-array", b + 3, 24'h000123, 16'h00FF);
    check("R6 done timing", 32'(dn_cyc - wl_cyc[(b+3)%1024]), 1);
    check("R7 ok code", 32'(dn_err), 0);
  endtask

  task automatic t_erase_prio;
    logic [7:0] sv [6] = '{8'h80, 8'hA0, 8'hB0, 8'h90, 8'h88, 8'hB2};
    logic [2:0] ev [6] = '{3'd0, 3'd2, 3'd1, 3'd3, 3'd5, 3'd4};
    for (int i = 0; i < 6; i++) begin
      int b = wl_n; int r = rl_n; int d = dn_n;
      cfg_max_polls = 8; done_after = 1; st_final = sv[i];
      issue(2'd1, 24'h000457, 6'd0);
      wait_done(d, "R3");
      check("R7 status class", 32'(dn_err), 32'(ev[i]));
      if (i == 1) begin
        check("R3 write count", 32'(wl_n - b), 4);
        chk_wr("R3 clear", b, 24'h000450, 16'h0050);
        chk_wr("R3 erase", b + 1, 24'h000450, 16'h0020);
        chk_wr("R3 confirm", b + 2, 24'h000450, 16'h00D0);
        chk_wr("R6 read-array", b + 3, 24'h000450, 16'h00FF);
        check("R3 poll addr", 32'(rl_addr[r%1024]), 32'h000450);
      end
    end
  endtask

  task automatic t_buf;
    int b = wl_n; int r = rl_n; int d = dn_n;
    cfg_max_polls = 8; brdy_after = 1; done_after = 0; st_final = 8'h80;
    enq(16'h1111); enq(16'h2222); enq(16'h3333); enq(16'h4444);
    issue(2'd2, 24'h000205, 6'd4);
    wait_done(d, "R4");
    check("R4 write count", 32'(wl_n - b), 9);
    chk_wr("R4 clear", b, 24'h000200, 16'h0050);
    chk_wr("R4 load", b + 1, 24'h000200, 16'h00E8);
    chk_wr("R4 count", b + 2, 24'h000200, 16'h0003);
    chk_wr("R4 word0", b + 3, 24'h000205, 16'h1111);
    chk_wr("R4 word1", b + 4, 24'h000206, 16'h2222);
    chk_wr("R4 word2", b + 5, 24'h000207, 16'h3333);
    chk_wr("R4 word3", b + 6, 24'h000208, 16'h4444);
    chk_wr("R4 confirm", b + 7, 24'h000200, 16'h00D0);
    chk_wr("R6 read-array", b + 8, 24'h000208, 16'h00FF);
    check("R4 read count", 32'(rl_n - r), 3);
    check("R4 ready poll", 32'(rl_addr[(r+1)%1024]), 32'h000200);
    check("R4 final poll", 32'(rl_addr[(r+2)%1024]), 32'h000208);
    check("R4 code", 32'(dn_err), 0);
  endtask

  task automatic t_buf_one;
    int b = wl_n; int d = dn_n;
    cfg_max_polls = 8; brdy_after = 0; done_after = 0; st_final = 8'h80;
    enq(16'h5A5A);
    issue(2'd2, 24'h000310, 6'd1);
    wait_done(d, "R4");
    check("R4 single write count", 32'(wl_n - b), 6);
    chk_wr("R4 single count", b + 2, 24'h000310, 16'h0000);
    chk_wr("R4 single word", b + 3, 24'h000310, 16'h5A5A);
  endtask

  task automatic t_timeout_final;
    int b = wl_n; int r = rl_n; int d = dn_n;
    cfg_max_polls = 5; done_after = 1000;
    enq(16'h0A0A);
    issue(2'd0, 24'h000600, 6'd1);
    wait_done(d, "R5");
    check("R5 timeout reads", 32'(rl_n - r), 5);
    check("R5 timeout code", 32'(dn_err), 6);
    chk_wr("R6 read-array", b + 3, 24'h000600, 16'h00FF);
  endtask

  task automatic t_timeout_buf;
    int b = wl_n; int r = rl_n; int d = dn_n; int q = wq_rd;
    cfg_max_polls = 3; brdy_after = 1000;
    enq(16'h7777); enq(16'h8888);
    issue(2'd2, 24'h000723, 6'd2);
    wait_done(d, "R5");
    check("R5 buffer wait reads", 32'(rl_n - r), 3);
    check("R5 buffer wait code", 32'(dn_err), 6);
    check("R5 buffer writes", 32'(wl_n - b), 3);
    chk_wr("R6 read-array", b + 2, 24'h000720, 16'h00FF);
    check("R5 no words taken", 32'(wq_rd - q), 0);
    wq_n = wq_rd;
    brdy_after = 0;
  endtask

  task automatic t_limit_zero;
    int r = rl_n; int d = dn_n;
    cfg_max_polls = 0; done_after = 1000;
    issue(2'd1, 24'h000800, 6'd0);
    wait_done(d, "R5");
    check("R5 zero limit reads", 32'(rl_n - r), 1);
    check("R5 zero limit code", 32'(dn_err), 6);
    cfg_max_polls = 8;
  endtask

  task automatic t_stall;
    int b = wl_n; int d = dn_n;
    cfg_max_polls = 8; done_after = 0; st_final = 8'h80;
    wd_hold = 1'b1;
    enq(16'hC3C3);
    issue(2'd0, 24'h000901, 6'd1);
    repeat (12) @(negedge clk);
    check("R9 writes while starved", 32'(wl_n - b), 2);
    check("R9 waiting", 32'(wdat_ready), 1);
    wd_hold = 1'b0;
    wait_done(d, "R9");
    chk_wr("R9 data after release", b + 2, 24'h000901, 16'hC3C3);
  endtask

  task automatic t_ignored;
    int b = wl_n; int r = rl_n; int d = dn_n;
    issue(2'd3, 24'h000A00, 6'd1);
    repeat (10) @(negedge clk);
    check("R8 reserved no writes", 32'(wl_n - b), 0);
    check("R8 reserved no reads", 32'(rl_n - r), 0);
    check("R8 reserved no done", 32'(dn_n - d), 0);
    check("R8 reserved ready", 32'(req_ready), 1);
  endtask

  task automatic t_busy;
    int b = wl_n; int d = dn_n;
    cfg_max_polls = 8; done_after = 4; st_final = 8'h80;
    issue(2'd1, 24'h000B09, 6'd0);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd1; req_addr = 24'h000777;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(d, "R8");
    repeat (10) @(negedge clk);
    check("R8 busy single done", 32'(dn_n - d), 1);
    check("R8 busy write count", 32'(wl_n - b), 4);
    check("R8 busy addr", 32'(wl_addr[(b+3)%1024]), 32'h000B00);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_word();
    t_erase_prio();
    t_buf();
    t_buf_one();
    t_timeout_final();
    t_timeout_buf();
    t_limit_zero();
    t_stall();
    t_ignored();
    t_busy();
    summary();
    $finish;
  end
endmodule